// File: doc/BRIEF.md
# Receive Ring Frame Writer

This block stores received Ethernet frames into a circular buffer held in local packet RAM. The buffer is divided into 256-byte pages between a first page and a limit page. A host-owned boundary page marks how far software has drained the buffer. For each frame the block first receives a descriptor that carries the frame length and a precomputed 6-bit multicast hash index. It then consumes the frame bytes from a valid/ready byte stream. The first six bytes are the destination address, and the block uses them to decide whether the frame is kept.

A kept frame is written one byte per cycle through a RAM write port. A 4-byte header goes at offset 0 of the current page, and the frame data starts at offset 4. Frames shorter than the minimum length are padded with zeros. When the write address reaches the limit page, it wraps back to the first page. When the frame is complete, the current page pointer moves to the page reserved for the next frame, the status byte is updated and a one-cycle interrupt pulse is raised. A frame that is refused or filtered out is still drained from the stream, but it touches neither the RAM nor the pointer, status or interrupt.

Back-pressure works as follows. A descriptor is taken only in a cycle where `dsc_valid` and `dsc_ready` are both high. `dsc_ready` is high only while no frame is in progress. A stream byte is taken in a cycle where `in_valid` and `in_ready` are both high. `in_ready` drops while the header and the held destination bytes are being written. The producer must send exactly `dsc_len` bytes after each descriptor. Page configuration, filter settings and the station address must stay stable while a frame is in progress.

Top module: `rx_ring_writer`

## Requirements
- R1: `dsc_ready` is high exactly when no frame is in progress, and then `in_ready` is low and no RAM write occurs. Every frame carries at least 6 bytes.
- R2: A descriptor taken while `ctl_run` is low is refused. Its bytes are consumed with no RAM write and no change to `cur_pg`, `rx_status` or `rx_irq`.
- R3: Free space is computed from the current page C, boundary page B, first page S and limit page L, with every page counted as 256 bytes. It is (B−C)·256 when C<B, and otherwise ((L−S)−(C−B))·256. `buf_full` is high when free space is below 1518 bytes. A descriptor taken while `buf_full` is high is refused in the same way as in R2.
- R4: With `rx_cfg` bit 4 set, every non-refused frame is kept.
- R5: Otherwise, a destination of six 0xFF bytes is kept only if `rx_cfg` bit 2 is set.
- R6: Otherwise, a destination whose first byte has bit 0 set is a group address. It is kept only if `rx_cfg` bit 3 is set and bit `dsc_hash` of `mc_filter` is set. That is filter byte hash>>3, bit hash&7, with byte k at bits 8k+7..8k.
- R7: Otherwise, the frame is kept only if the six destination bytes equal `sta_addr`. The first received byte is compared with bits 7:0, the second with bits 15:8, and so on.
- R8: A frame that is filtered out is consumed with no RAM write and no change to pointer, status or interrupt.
- R9: A kept frame shorter than 60 bytes is stored as 60 bytes, with zero bytes following the received data.
- R10: For a kept frame at current page C, the block writes the header first. Address C·256+0 receives the status byte, +1 the next page, +2 the low byte of T and +3 the high byte of T, where T = stored length + 4. The frame bytes then follow in order from C·256+4.
- R11: The status byte is 0x01, OR'd with 0x20 when the first destination byte has bit 0 set.
- R12: The next page is N = C + floor((T+4+255)/256). If N ≥ L, then N − (L−S) is used instead.
- R13: After a data byte is written at address A, the next data byte goes to A+1, unless A+1 equals L·256, in which case it goes to S·256.
- R14: When a kept frame's last write is done, `cur_pg` becomes the next page and `rx_status` takes the frame's status byte. In that same cycle `rx_irq` is high, for one cycle only. A `cur_ld` request is applied only while no frame is in progress and no descriptor is being taken. A request at any other time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_run | input | 1 | Receiver running; low refuses frames |
| rx_cfg | input | 8 | Receive filter config (bit 2 broadcast, bit 3 group, bit 4 accept all) |
| sta_addr | input | 48 | Station address, first byte in bits 7:0 |
| mc_filter | input | 64 | Group hash filter, bit index = hash |
| pg_start | input | 8 | First page of the ring |
| pg_stop | input | 8 | Limit page (one past the last ring page) |
| pg_bound | input | 8 | Host boundary page |
| cur_ld | input | 1 | Host request to load the current page |
| cur_ld_pg | input | 8 | Page value for `cur_ld` |
| dsc_valid | input | 1 | Frame descriptor valid |
| dsc_ready | output | 1 | Descriptor accepted (block idle) |
| dsc_len | input | 11 | Frame length in bytes (at least 6) |
| dsc_hash | input | 6 | Group hash index of the frame |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Frame byte accepted |
| in_data | input | 8 | Frame byte |
| ram_we | output | 1 | Packet RAM write strobe |
| ram_addr | output | 16 | Packet RAM byte address |
| ram_wdata | output | 8 | Packet RAM write data |
| cur_pg | output | 8 | Current page pointer |
| rx_status | output | 8 | Status byte of the last kept frame |
| rx_irq | output | 1 | One-cycle pulse per kept frame |
| buf_full | output | 1 | Free space below one maximum frame |

## Verification
Two functions can fall in the same clock edge: the commit of a finished frame, which advances `cur_pg`, and a host page load. The bench provokes this by holding `cur_ld` with an unrelated page value from the cycle after the descriptor is taken until the block is idle again. This spans the commit cycle. The check passes only if `cur_pg` ends at the next page the bench computes from R12, not at the loaded value. A scoreboard compares every RAM write against the address and data sequence derived from R9, R10 and R13, including a frame that wraps mid-data and one whose next page lands exactly on the limit.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int unsigned PAGE_SH   = 8;
  localparam int unsigned DST_BYTES = 6;
  localparam int unsigned HDR_BYTES = 4;
  localparam int unsigned CRC_BYTES = 4;

  localparam logic [7:0] ST_OK    = 8'h01;
  localparam logic [7:0] ST_GROUP = 8'h20;

  typedef enum logic [3:0] {
    S_IDLE,
    S_GATHER,
    S_DECIDE,
    S_HDR,
    S_FLUSH,
    S_BODY,
    S_PAD,
    S_COMMIT,
    S_DROP
  } rxw_state_e;
endpackage

// File: rtl/rxr_space.sv
module rxr_space #(
  parameter int unsigned PG_W    = 8,
  parameter int unsigned MAX_LEN = 1514
) (
  input  logic [PG_W-1:0] cur,
  input  logic [PG_W-1:0] bound,
  input  logic [PG_W-1:0] first,
  input  logic [PG_W-1:0] limit,
  output logic            full
);
  import rxr_pkg::*;
  localparam int unsigned NEED_BYTES = MAX_LEN + HDR_BYTES;
  localparam int unsigned NEED_PG    = (NEED_BYTES + (1 << PAGE_SH) - 1) >> PAGE_SH;
  localparam int unsigned SW         = PG_W + 2;

  logic signed [SW-1:0] ring_pg, used_pg, avail_pg;

  always_comb begin
    ring_pg = $signed({2'b00, limit}) - $signed({2'b00, first});
    used_pg = $signed({2'b00, cur}) - $signed({2'b00, bound});
    if (cur < bound) avail_pg = -used_pg;
    else             avail_pg = ring_pg - used_pg;
    full = (avail_pg < $signed(SW'(NEED_PG)));
  end

  // R3: with current equal to boundary the whole ring is free
  always_comb begin
    if (cur == bound && ring_pg >= $signed(SW'(NEED_PG)))
      a_r3_empty_ring_room: assert (!full);
  end
endmodule

// File: rtl/rxr_filter.sv
module rxr_filter #(
  parameter int unsigned HASH_W = 6
) (
  input  logic [rxr_pkg::DST_BYTES*8-1:0] dst,
  input  logic [rxr_pkg::DST_BYTES*8-1:0] station,
  input  logic                            take_all,
  input  logic                            take_bcast,
  input  logic                            take_group,
  input  logic [(1<<HASH_W)-1:0]          filt,
  input  logic [HASH_W-1:0]               hash,
  output logic                            keep,
  output logic                            group
);
  logic bcast, own;

  always_comb begin
    bcast = &dst;
    group = dst[0];
    own   = (dst == station);
    if (take_all)   keep = 1'b1;
    else if (bcast) keep = take_bcast;
    else if (group) keep = take_group & filt[hash];
    else            keep = own;
  end
endmodule

// File: rtl/rxr_pager.sv
module rxr_pager #(
  parameter int unsigned PG_W    = 8,
  parameter int unsigned LEN_W   = 11,
  parameter int unsigned MIN_LEN = 60
) (
  input  logic [PG_W-1:0]   cur,
  input  logic [PG_W-1:0]   first,
  input  logic [PG_W-1:0]   limit,
  input  logic [LEN_W-1:0]  len,
  output logic [PG_W+7:0]   total,
  output logic [PG_W-1:0]   next_pg
);
  import rxr_pkg::*;
  localparam int unsigned TW = PG_W + PAGE_SH;

  logic [TW-1:0]   stored, span;
  logic [PG_W:0]   sum, adj;
  logic            unused_top;

  always_comb begin
    stored  = (len < LEN_W'(MIN_LEN)) ? TW'(MIN_LEN) : TW'(len);
    total   = stored + TW'(HDR_BYTES);
    span    = total + TW'(CRC_BYTES + (1 << PAGE_SH) - 1);
    sum     = {1'b0, cur} + {1'b0, span[TW-1:PAGE_SH]};
    if (sum >= {1'b0, limit}) adj = sum - {1'b0, limit - first};
    else                      adj = sum;
    next_pg = adj[PG_W-1:0];
  end
  assign unused_top = adj[PG_W];
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int unsigned PG_W    = 8,
  parameter int unsigned LEN_W   = 11,
  parameter int unsigned HASH_W  = 6,
  parameter int unsigned MIN_LEN = 60,
  parameter int unsigned MAX_LEN = 1514
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctl_run,
  input  logic [7:0]             rx_cfg,
  input  logic [47:0]            sta_addr,
  input  logic [(1<<HASH_W)-1:0] mc_filter,
  input  logic [PG_W-1:0]        pg_start,
  input  logic [PG_W-1:0]        pg_stop,
  input  logic [PG_W-1:0]        pg_bound,
  input  logic                   cur_ld,
  input  logic [PG_W-1:0]        cur_ld_pg,
  input  logic                   dsc_valid,
  output logic                   dsc_ready,
  input  logic [LEN_W-1:0]       dsc_len,
  input  logic [HASH_W-1:0]      dsc_hash,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [7:0]             in_data,
  output logic                   ram_we,
  output logic [PG_W+7:0]        ram_addr,
  output logic [7:0]             ram_wdata,
  output logic [PG_W-1:0]        cur_pg,
  output logic [7:0]             rx_status,
  output logic                   rx_irq,
  output logic                   buf_full
);
  import rxr_pkg::*;
  localparam int unsigned AW = PG_W + PAGE_SH;
  localparam logic [LEN_W-1:0] LEN_DST = LEN_W'(DST_BYTES);
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
  localparam logic [2:0]       IDX_DST = 3'(DST_BYTES - 1);
  localparam logic [2:0]       IDX_HDR = 3'(HDR_BYTES - 1);

  rxw_state_e        state_q;
  logic [LEN_W-1:0]  len_q, cnt_q, cnt_inc;
  logic [HASH_W-1:0] hash_q;
  logic [2:0]        idx_q;
  logic [7:0]        dst_q [DST_BYTES];
  logic [AW-1:0]     wptr_q, wptr_inc, wptr_nx;
  logic [PG_W-1:0]   nxt_q, cur_q, nxt_w;
  logic [7:0]        stat_q, sts_q;
  logic              irq_q;
  logic [AW-1:0]     tot_w;
  logic [DST_BYTES*8-1:0] dst_flat;
  logic              keep_w, group_w, full_w, take_dsc;
  logic              unused_cfg;

  assign unused_cfg = ^{rx_cfg[7:5], rx_cfg[1:0]};

  for (genvar g = 0; g < DST_BYTES; g++) begin : g_dst
    assign dst_flat[g*8 +: 8] = dst_q[g];
  end

  rxr_space #(.PG_W(PG_W), .MAX_LEN(MAX_LEN)) u_space (
    .cur(cur_q), .bound(pg_bound), .first(pg_start), .limit(pg_stop), .full(full_w)
  );

  rxr_filter #(.HASH_W(HASH_W)) u_filter (
    .dst(dst_flat), .station(sta_addr),
    .take_all(rx_cfg[4]), .take_bcast(rx_cfg[2]), .take_group(rx_cfg[3]),
    .filt(mc_filter), .hash(hash_q), .keep(keep_w), .group(group_w)
  );

  rxr_pager #(.PG_W(PG_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_pager (
    .cur(cur_q), .first(pg_start), .limit(pg_stop), .len(len_q),
    .total(tot_w), .next_pg(nxt_w)
  );

  assign cnt_inc  = cnt_q + LEN_ONE;
  assign wptr_inc = wptr_q + AW'(1);
  assign wptr_nx  = (wptr_inc == {pg_stop, PAGE_SH'(0)}) ? {pg_start, PAGE_SH'(0)} : wptr_inc;
  assign take_dsc = dsc_valid && (state_q == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      len_q   <= '0;
      cnt_q   <= '0;
      hash_q  <= '0;
      idx_q   <= '0;
      wptr_q  <= '0;
      nxt_q   <= '0;
      cur_q   <= '0;
      stat_q  <= '0;
      sts_q   <= '0;
      irq_q   <= 1'b0;
      for (int i = 0; i < DST_BYTES; i++) dst_q[i] <= '0;
    end else begin
      irq_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (take_dsc) begin
            len_q   <= dsc_len;
            hash_q  <= dsc_hash;
            idx_q   <= '0;
            cnt_q   <= '0;
            state_q <= (ctl_run && !full_w) ? S_GATHER : S_DROP;
          end else if (cur_ld) begin
            cur_q <= cur_ld_pg;
          end
        end
        S_GATHER: begin
          if (in_valid) begin
            dst_q[idx_q] <= in_data;
            idx_q        <= idx_q + 3'd1;
            if (idx_q == IDX_DST) begin
              idx_q   <= '0;
              state_q <= S_DECIDE;
            end
          end
        end
        S_DECIDE: begin
          if (keep_w) begin
            stat_q  <= ST_OK | (group_w ? ST_GROUP : 8'h00);
            nxt_q   <= nxt_w;
            state_q <= S_HDR;
          end else begin
            cnt_q   <= LEN_DST;
            state_q <= (len_q == LEN_DST) ? S_IDLE : S_DROP;
          end
        end
        S_HDR: begin
          idx_q <= idx_q + 3'd1;
          if (idx_q == IDX_HDR) begin
            idx_q   <= '0;
            wptr_q  <= {cur_q, PAGE_SH'(HDR_BYTES)};
            state_q <= S_FLUSH;
          end
        end
        S_FLUSH: begin
          wptr_q <= wptr_nx;
          idx_q  <= idx_q + 3'd1;
          if (idx_q == IDX_DST) begin
            idx_q   <= '0;
            cnt_q   <= LEN_DST;
            state_q <= (len_q > LEN_DST) ? S_BODY : S_PAD;
          end
        end
        S_BODY: begin
          if (in_valid) begin
            wptr_q <= wptr_nx;
            cnt_q  <= cnt_inc;
            if (cnt_inc == len_q) state_q <= (cnt_inc < LEN_MIN) ? S_PAD : S_COMMIT;
          end
        end
        S_PAD: begin
          wptr_q <= wptr_nx;
          cnt_q  <= cnt_inc;
          if (cnt_inc >= LEN_MIN) state_q <= S_COMMIT;
        end
        S_COMMIT: begin
          cur_q   <= nxt_q;
          sts_q   <= stat_q;
          irq_q   <= 1'b1;
          state_q <= S_IDLE;
        end
        S_DROP: begin
          if (in_valid) begin
            cnt_q <= cnt_inc;
            if (cnt_inc == len_q) state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    dsc_ready = (state_q == S_IDLE);
    in_ready  = (state_q == S_GATHER) || (state_q == S_BODY) || (state_q == S_DROP);
    ram_we    = 1'b0;
    ram_addr  = wptr_q;
    ram_wdata = 8'h00;
    case (state_q)
      S_HDR: begin
        ram_we   = 1'b1;
        ram_addr = {cur_q, PAGE_SH'(idx_q)};
        case (idx_q[1:0])
          2'd0:    ram_wdata = stat_q;
          2'd1:    ram_wdata = nxt_q;
          2'd2:    ram_wdata = tot_w[7:0];
          default: ram_wdata = tot_w[15:8];
        endcase
      end
      S_FLUSH: begin
        ram_we    = 1'b1;
        ram_wdata = dst_q[idx_q];
      end
      S_BODY: begin
        ram_we    = in_valid;
        ram_wdata = in_data;
      end
      S_PAD: ram_we = 1'b1;
      default: ;
    endcase
  end

  assign cur_pg    = cur_q;
  assign rx_status = sts_q;
  assign rx_irq    = irq_q;
  assign buf_full  = full_w;

  // R1: idle means no stream intake and no RAM traffic
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_ready |-> (!ram_we && !in_ready));
  // R14: interrupt is a single-cycle pulse
  a_r14_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);
  // R14: the page pointer moves only on a host load or a frame commit
  a_r14_cur_source: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_ld |=> (rx_irq || $stable(cur_pg)));
  // R13: writes never land at or beyond the limit page
  a_r13_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && pg_start < pg_stop && cur_pg < pg_stop) |-> (ram_addr[AW-1:PAGE_SH] < pg_stop));
endmodule

// File: tb/rx_ring_writer_tb.sv
`timescale 1ns/1ps
module rx_ring_writer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_run = 1'b1;
  logic [7:0]  rx_cfg = 8'h00;
  logic [47:0] sta_addr = 48'h5A4B3C2D1E02;
  logic [63:0] mc_filter = 64'h0;
  logic [7:0]  pg_start = 8'h40, pg_stop = 8'h60, pg_bound = 8'h40;
  logic        cur_ld = 1'b0;
  logic [7:0]  cur_ld_pg = 8'h00;
  logic        dsc_valid = 1'b0;
  logic        dsc_ready;
  logic [10:0] dsc_len = '0;
  logic [5:0]  dsc_hash = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        ram_we;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  cur_pg, rx_status;
  logic        rx_irq, buf_full;

  always #4 clk = ~clk;

  rx_ring_writer u_dut (
    .clk, .rst_n, .ctl_run, .rx_cfg, .sta_addr, .mc_filter,
    .pg_start, .pg_stop, .pg_bound, .cur_ld, .cur_ld_pg,
    .dsc_valid, .dsc_ready, .dsc_len, .dsc_hash,
    .in_valid, .in_ready, .in_data,
    .ram_we, .ram_addr, .ram_wdata, .cur_pg, .rx_status, .rx_irq, .buf_full
  );

  int checks = 0, fails = 0;
  int irq_seen = 0;
  bit prev_irq = 1'b0;
  bit done = 1'b0;
  logic [23:0] exp_q[$];
  logic [7:0]  cur_m = 8'h00, st_m = 8'h00;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (ram_we) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 stray RAM write", {ram_addr, ram_wdata}, 0);
        else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          chk(ram_addr == e[23:8] && ram_wdata == e[7:0], "R10/R13 write stream",
              {ram_addr, ram_wdata}, e);
        end
      end
      if (rx_irq) irq_seen++;
      if (rx_irq && prev_irq) chk(1'b0, "R14 irq wider than one cycle", 2, 1);
      prev_irq = rx_irq;
    end
  end

  function automatic bit model_full();
    int av;
    if (cur_m < pg_bound) av = pg_bound - cur_m;
    else av = (pg_stop - pg_start) - (cur_m - pg_bound);
    return (av * 256) < 1518;
  endfunction

  task automatic set_cur(input logic [7:0] p);
    cur_ld = 1'b1; cur_ld_pg = p;
    @(negedge clk);
    cur_ld = 1'b0;
    cur_m = p;
    @(negedge clk);
    chk(cur_pg == p, "R14 idle host load", cur_pg, p);
  endtask

  task automatic run_frame(input int len, input logic [47:0] dst, input logic [5:0] hash,
                           input bit hold, input string tag);
    logic [7:0] fr[];
    bit keep, refused;
    int plen, tot, nx, a, irq0;
    logic [7:0] st;
    fr = new[len];
    for (int i = 0; i < len; i++)
      fr[i] = (i < 6) ? dst[8*i +: 8] : 8'((i * 13 + len) & 8'hff);
    refused = !ctl_run || model_full();
    if (refused) keep = 1'b0;
    else if (rx_cfg[4]) keep = 1'b1;
    else if (dst == 48'hFFFFFFFFFFFF) keep = rx_cfg[2];
    else if (dst[0]) keep = rx_cfg[3] && mc_filter[hash];
    else keep = (dst == sta_addr);
    if (keep) begin
      plen = (len < 60) ? 60 : len;
      tot  = plen + 4;
      nx   = cur_m + (tot + 4 + 255) / 256;
      if (nx >= pg_stop) nx = nx - (pg_stop - pg_start);
      st = 8'h01 | (dst[0] ? 8'h20 : 8'h00);
      exp_q.push_back({cur_m, 8'd0, st});
      exp_q.push_back({cur_m, 8'd1, 8'(nx)});
      exp_q.push_back({cur_m, 8'd2, 8'(tot & 255)});
      exp_q.push_back({cur_m, 8'd3, 8'(tot >> 8)});
      a = cur_m * 256 + 4;
      for (int i = 0; i < plen; i++) begin
        exp_q.push_back({16'(a), (i < len) ? fr[i] : 8'h00});
        a++;
        if (a == pg_stop * 256) a = pg_start * 256;
      end
    end else begin
      nx = cur_m;
      st = st_m;
    end
    irq0 = irq_seen;
    dsc_valid = 1'b1; dsc_len = 11'(len); dsc_hash = hash;
    while (!dsc_ready) @(negedge clk);
    @(negedge clk);
    dsc_valid = 1'b0;
    if (hold) begin cur_ld = 1'b1; cur_ld_pg = 8'h77; end
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1; in_data = fr[i];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    while (!dsc_ready) @(negedge clk);
    cur_ld = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, {tag, ": R10 all expected writes seen"}, exp_q.size(), 0);
    exp_q.delete();
    chk(cur_pg == 8'(nx), {tag, ": R12/R14 current page"}, cur_pg, nx);
    chk(rx_status == st, {tag, ": R11 status byte"}, rx_status, st);
    chk((irq_seen - irq0) == int'(keep), {tag, ": R14 irq count"}, irq_seen - irq0, keep);
    cur_m = 8'(nx);
    st_m  = st;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(cur_pg == 8'h00, "R1 reset cur_pg", cur_pg, 0);
    chk(rx_status == 8'h00, "R1 reset status", rx_status, 0);
    chk(!rx_irq && !ram_we, "R1 reset quiet outputs", {rx_irq, ram_we}, 0);
    chk(dsc_ready && !in_ready, "R1 idle handshake", {dsc_ready, in_ready}, 2);

    set_cur(8'h40);
    chk(buf_full == 1'b0, "R3 empty ring not full", buf_full, 0);

    run_frame(64, 48'h5A4B3C2D1E02, 6'd0, 1'b0, "R7 unicast match");
    run_frame(64, 48'h5A4B3C2D1E04, 6'd0, 1'b0, "R8 unicast mismatch");
    run_frame(20, 48'h5A4B3C2D1E02, 6'd0, 1'b0, "R9 short padded");
    run_frame(70, 48'hFFFFFFFFFFFF, 6'd0, 1'b0, "R5 broadcast off");
    rx_cfg = 8'h04;
    run_frame(70, 48'hFFFFFFFFFFFF, 6'd0, 1'b0, "R5 broadcast on");
    mc_filter = 64'h0000_2000_0000_0000;   // bit 45 = byte 5 bit 5
    rx_cfg = 8'h0C;
    run_frame(80, 48'h0000005E0001, 6'd45, 1'b0, "R6 group hit");
    run_frame(80, 48'h0000005E0001, 6'd44, 1'b0, "R6 group filter miss");
    rx_cfg = 8'h04;
    run_frame(80, 48'h0000005E0001, 6'd45, 1'b0, "R6 group disabled");
    rx_cfg = 8'h10;
    run_frame(64, 48'h112233445566, 6'd0, 1'b0, "R4 accept all");
    rx_cfg = 8'h00;

    // R3 boundary: 5 free pages full, 6 free pages not
    pg_bound = cur_m + 8'd5;
    @(negedge clk);
    chk(buf_full == 1'b1, "R3 five pages full", buf_full, 1);
    run_frame(64, 48'h5A4B3C2D1E02, 6'd0, 1'b0, "R3 refused when full");
    pg_bound = cur_m + 8'd6;
    @(negedge clk);
    chk(buf_full == 1'b0, "R3 six pages room", buf_full, 0);
    run_frame(64, 48'h5A4B3C2D1E02, 6'd0, 1'b0, "R3 accepted at limit");

    ctl_run = 1'b0;
    run_frame(64, 48'h5A4B3C2D1E02, 6'd0, 1'b0, "R2 stopped");
    ctl_run = 1'b1;

    pg_bound = 8'h50;
    set_cur(8'h5F);
    run_frame(300, 48'h5A4B3C2D1E02, 6'd0, 1'b0, "R13 data wrap");
    set_cur(8'h5F);
    run_frame(64, 48'h5A4B3C2D1E02, 6'd0, 1'b0, "R12 next equals limit");
    run_frame(6, 48'h5A4B3C2D1E02, 6'd0, 1'b0, "R9 six byte frame");
    run_frame(100, 48'h5A4B3C2D1E02, 6'd0, 1'b1, "R14 load during frame");
    run_frame(1514, 48'h5A4B3C2D1E02, 6'd0, 1'b0, "R12 max frame");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule